// File: doc/BRIEF.md
# Nibble-Bus Banked Register Window

This block is a slave on a narrow legacy peripheral bus that has four address lines, four data lines, one read/write line and one chip select. It answers on that bus as a sixteen-location clock register map. Locations 0x0 to 0xE hold BCD time and date nibbles. A local side port keeps these nibbles current, and a bus write can overwrite them.

Location 0xF does not hold a time field. It is a gateway to a larger banked memory. A bus write to 0xF selects one of sixteen banks and rewinds that bank's read pointer. Each bus read of 0xF returns the nibble under the pointer, and the pointer steps forward when the read strobe ends. Repeated reads of the one address therefore stream a whole bank. The same local port that updates the time nibbles also fills the banks.

The bus strobes are asynchronous to the system clock. They are brought in through two-flop synchronisers and turned into single-cycle edge pulses. The read data path is combinational from stored state, so the data is on the bus soon after the strobe rises and well inside a short access window.

Top module: `nbw_top`

## Requirements
- R1: After synchronous reset, locations 0x0 to 0xE read 0 on the bus. Bank 0 is selected and its pointer is 0, so the first read of 0xF returns bank 0, nibble 0.
- R2: `bus_oe` is 1 only while `bus_cs` = 1 and `bus_rnw` = 1 (1 means read). While `bus_oe` is 0, `bus_rdata` is 0.
- R3: A bus read of address A in 0x0 to 0xE returns the stored time nibble A. The data appears with no clock edge between the strobe and the data.
- R4: A local write with `loc_we` = 1 and `loc_bank` = 0 stores `loc_wdata` in time nibble `loc_addr[3:0]` (for values 0x0 to 0xE), and the bus sees it from the next clock edge.
- R5: A bus write (`bus_cs` = 1, `bus_rnw` = 0) to an address in 0x0 to 0xE replaces that time nibble. The new value is readable within 5 clock cycles after the strobe rises.
- R6: A bus write to 0xF makes the written nibble the selected bank and sets the pointer to 0, including in the middle of a stream.
- R7: A local write with `loc_we` = 1 and `loc_bank` = 1 stores `loc_wdata` at bank `loc_addr[7:4]`, nibble `loc_addr[3:0]`. A bus read of 0xF returns the nibble at the selected bank and the current pointer.
- R8: The pointer increases by 1 after each completed bus read of 0xF. Bus reads of 0x0 to 0xE leave it unchanged.
- R9: After nibble 15 of a bank, the pointer returns to 0 and the bank stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus chip select, active high, asynchronous |
| bus_rnw | input | 1 | Bus direction: 1 read, 0 write |
| bus_addr | input | 4 | Bus register address |
| bus_wdata | input | 4 | Bus write nibble |
| bus_rdata | output | 4 | Bus read nibble, 0 when not driving |
| bus_oe | output | 1 | Bus data output enable |
| loc_we | input | 1 | Local write enable |
| loc_bank | input | 1 | Local target: 0 time nibbles, 1 bank memory |
| loc_addr | input | 8 | Local address: bank in [7:4], nibble in [3:0] |
| loc_wdata | input | 4 | Local write nibble |

## Verification
The hardest case to reach from the ports is the pointer step at the end of a read. When that step happens, the bus address has often moved to some other location. The block must remember that the finished read targeted 0xF. To reach this case, the bench drops chip select and changes the address in the same step. It then checks that the next stream read returns the following nibble. It also checks the other direction: reads of time addresses placed between stream reads must not move the pointer. Running a full stream of seventeen reads through one bank reaches the wrap back to nibble 0. A write to 0xF in the middle of a stream checks that the pointer rewinds.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  typedef enum logic {
    LOC_TIME = 1'b0,
    LOC_BANK = 1'b1
  } loc_tgt_e;

  function automatic logic is_gate(input logic [3:0] a);
    return a == 4'hF;
  endfunction
endpackage

// File: rtl/nbw_sync.sv
module nbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/nbw_proto.sv
module nbw_proto #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bank,
  output logic [PTR_W-1:0]  ptr,
  output logic              sel_wr,
  output logic              step
);
  localparam logic [ADDR_W-1:0] GATE = '1;

  logic rd_on_gate;

  assign sel_wr = wr_go && (addr == GATE);
  assign step   = rd_done && rd_on_gate && !sel_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_on_gate <= 1'b0;
    end else if (rd_go) begin
      rd_on_gate <= (addr == GATE);
    end else if (rd_done) begin
      rd_on_gate <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
      ptr  <= '0;
    end else if (sel_wr) begin
      bank <= wdata;
      ptr  <= '0;
    end else if (step) begin
      ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/nbw_store.sv
module nbw_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int PTR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_waddr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    loc_we,
  input  logic                    loc_bank,
  input  logic [DATA_W+PTR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0]       loc_wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [DATA_W-1:0]       rd_bank,
  input  logic [PTR_W-1:0]        rd_ptr,
  output logic [DATA_W-1:0]       rd_data
);
  import nbw_pkg::*;
  localparam int NTIME = (1 << ADDR_W) - 1;
  localparam int DEPTH = 1 << (DATA_W + PTR_W);
  localparam logic [ADDR_W-1:0] GATE = '1;

  logic [DATA_W-1:0] time_q [NTIME];
  logic [DATA_W-1:0] mem    [DEPTH];
  logic [ADDR_W-1:0] loc_t;

  assign loc_t = loc_addr[ADDR_W-1:0];

  for (genvar i = 0; i < NTIME; i++) begin : g_time
    always_ff @(posedge clk) begin
      if (rst) begin
        time_q[i] <= '0;
      end else if (bus_wr && bus_waddr == ADDR_W'(i)) begin
        time_q[i] <= bus_wdata;
      end else if (loc_we && loc_bank == LOC_TIME && loc_t == ADDR_W'(i)) begin
        time_q[i] <= loc_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (loc_we && loc_bank == LOC_BANK) begin
      mem[loc_addr] <= loc_wdata;
    end
  end

  always_comb begin
    if (rd_addr == GATE) rd_data = mem[{rd_bank, rd_ptr}];
    else                 rd_data = time_q[rd_addr];
  end
endmodule

// File: rtl/nbw_top.sv
module nbw_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int PTR_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_cs,
  input  logic                    bus_rnw,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_oe,
  input  logic                    loc_we,
  input  logic                    loc_bank,
  input  logic [DATA_W+PTR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0]       loc_wdata
);
  localparam logic [ADDR_W-1:0] GATE = '1;

  logic rd_act, wr_act;
  logic rd_go, rd_done, wr_go, wr_done;
  logic sel_wr, step;
  logic [DATA_W-1:0] bank, store_data;
  logic [PTR_W-1:0]  ptr;

  assign rd_act = bus_cs & bus_rnw;
  assign wr_act = bus_cs & ~bus_rnw;

  nbw_sync #(.STAGES(SYNC_N)) u_rd_sync (
    .clk(clk), .rst(rst), .async_in(rd_act), .rise(rd_go), .fall(rd_done)
  );

  nbw_sync #(.STAGES(SYNC_N)) u_wr_sync (
    .clk(clk), .rst(rst), .async_in(wr_act), .rise(wr_go), .fall(wr_done)
  );

  nbw_proto #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_proto (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .rd_done(rd_done),
    .addr(bus_addr), .wdata(bus_wdata), .bank(bank), .ptr(ptr),
    .sel_wr(sel_wr), .step(step)
  );

  nbw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst(rst),
    .bus_wr(wr_go && bus_addr != GATE), .bus_waddr(bus_addr), .bus_wdata(bus_wdata),
    .loc_we(loc_we), .loc_bank(loc_bank), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .rd_addr(bus_addr), .rd_bank(bank), .rd_ptr(ptr), .rd_data(store_data)
  );

  assign bus_oe    = rd_act;
  assign bus_rdata = rd_act ? store_data : '0;

  logic unused_wr_done;
  assign unused_wr_done = wr_done;
endmodule

// File: rtl/nbw_checker.sv
module nbw_checker #(
  parameter int DATA_W = 4,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sel_wr,
  input logic              step,
  input logic [DATA_W-1:0] bank,
  input logic [PTR_W-1:0]  ptr
);
  // R2: an idle bus is never driven
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_cs |-> (!bus_oe && bus_rdata == '0));

  // R6: bank selection rewinds the pointer
  p_sel_rewind_r6: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> ptr == '0);

  // R8, R9: each completed gate read steps the pointer modulo the bank size
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    step |=> ptr == $past(ptr) + 1'b1);

  // R8: without a step or selection the pointer holds
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!step && !sel_wr) |=> $stable(ptr));

  // R6: the bank changes only on a gate write
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(bank));
endmodule

bind nbw_top nbw_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_rdata(bus_rdata),
  .sel_wr(sel_wr), .step(step), .bank(bank), .ptr(ptr)
);

// File: tb/tb_nbw_top.sv
module tb_nbw_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_cs, bus_rnw;
  logic [3:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_oe;
  logic       loc_we, loc_bank;
  logic [7:0] loc_addr;
  logic [3:0] loc_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  nbw_top dut (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .loc_we(loc_we), .loc_bank(loc_bank), .loc_addr(loc_addr), .loc_wdata(loc_wdata)
  );

  function automatic logic [3:0] pat(input int b, input int p);
    return 4'((b * 3 + p * 5 + 1) & 15);
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_rnw = 1'b1; bus_cs = 1'b1;
    #1 d = bus_rdata;
    repeat (4) @(negedge clk);
    bus_cs = 1'b0; bus_rnw = 1'b0; bus_addr = 4'h3;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rnw = 1'b0; bus_cs = 1'b1;
    repeat (5) @(negedge clk);
    bus_cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic loc_write(input logic b, input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_bank = b; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic fill_bank(input int b);
    for (int p = 0; p < 16; p++) loc_write(1'b1, 8'((b << 4) | p), pat(b, p));
  endtask

  task automatic t_reset;
    logic [3:0] d;
    for (int a = 0; a < 15; a++) begin
      bus_read(4'(a), d);
      check("R1 time zero", d, 4'h0);
    end
    bus_read(4'hF, d);
    check("R1 bank0 nibble0", d, pat(0, 0));
  endtask

  task automatic t_oe;
    @(negedge clk);
    bus_cs = 1'b0; bus_rnw = 1'b1; #1;
    check("R2 oe idle", {3'b0, bus_oe}, 4'h0);
    check("R2 rdata idle", bus_rdata, 4'h0);
    bus_cs = 1'b1; bus_rnw = 1'b0; #1;
    check("R2 oe on write", {3'b0, bus_oe}, 4'h0);
    bus_cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_local_time;
    logic [3:0] d;
    loc_write(1'b0, 8'h05, 4'h7);
    loc_write(1'b0, 8'h0E, 4'h9);
    bus_read(4'h5, d); check("R4 local time 5", d, 4'h7);
    bus_read(4'hE, d); check("R3 read time E", d, 4'h9);
  endtask

  task automatic t_bus_time;
    logic [3:0] d;
    bus_write(4'h2, 4'h4);
    bus_read(4'h2, d); check("R5 bus time 2", d, 4'h4);
    bus_read(4'h5, d); check("R5 neighbour kept", d, 4'h7);
  endtask

  task automatic t_stream;
    logic [3:0] d;
    bus_write(4'hF, 4'h2);
    for (int p = 0; p < 16; p++) begin
      bus_read(4'hF, d); check("R7 stream bank2", d, pat(2, p));
    end
    bus_read(4'hF, d); check("R9 wrap to nibble0", d, pat(2, 0));
  endtask

  task automatic t_interleave;
    logic [3:0] d;
    bus_write(4'hF, 4'hF);
    bus_read(4'hF, d); check("R7 bank15 n0", d, pat(15, 0));
    bus_read(4'h2, d); check("R8 time read between", d, 4'h4);
    bus_read(4'h5, d);
    bus_read(4'hF, d); check("R8 pointer held", d, pat(15, 1));
    bus_read(4'hF, d); check("R8 pointer step", d, pat(15, 2));
    bus_write(4'hF, 4'h2);
    bus_read(4'hF, d); check("R6 rewind mid stream", d, pat(2, 0));
    bus_write(4'hF, 4'h0);
    bus_read(4'hF, d); check("R6 reselect bank0", d, pat(0, 0));
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    rst = 1'b1; bus_cs = 1'b0; bus_rnw = 1'b0; bus_addr = 4'h0; bus_wdata = 4'h0;
    loc_we = 1'b0; loc_bank = 1'b0; loc_addr = 8'h00; loc_wdata = 4'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fill_bank(0);
    fill_bank(2);
    fill_bank(15);
    t_reset();
    t_oe();
    t_local_time();
    t_bus_time();
    t_stream();
    t_interleave();
    done = 1'b1;
    report();
  end
endmodule